// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a deserializer that delivers ten-bit symbols packed two or four to a word, one word per user clock. Bit 0 of each word is the earliest bit on the line. The block hunts the bit stream for a plus or a minus comma and moves the symbol boundary so that a found comma starts exactly on a lane edge of the output word. Each pattern bit can be made a don't-care through a ten-bit care mask. One mode lets a comma settle in any lane. The other forces it into an even lane, for protocols that need commas in a fixed half of the word.

User logic can instead steer the boundary by hand through a slide input. Each accepted rising edge moves the boundary by one bit. Edges that come too soon after the previous high period are dropped. While the slide input is high, automatic alignment is frozen. The output word, a per-lane comma flag and an aligned flag all leave the block together, one word after the input.

Top module: `comma_word_aligner`

## Requirements
- R1: An accepted slide edge moves the bit offset up by exactly one, wrapping from WORD_W-1 to 0. A slide input held high for several cycles gives only one move.
- R2: A rising edge of slide_i is accepted only if slide_i was low for more than SLIDE_GAP (16) consecutive cycles just before it. A rejected edge changes nothing and restarts the low count. The first edge after reset is accepted.
- R3: While slide_i is high, a found comma never changes the offset.
- R4: A ten-bit slice matches a pattern when every bit set in care_mask_i agrees with the pattern. plus_align_en_i and minus_align_en_i each let their own pattern drive alignment. lane_comma_o[l] is set when detect_en_i is 1 and output lane l (bits 10l+9..10l) matches either pattern, whatever the align enables are.
- R5: The search window is the current word placed above the previous word, so bit p of the window is previous-word bit p for p < WORD_W. Every start position 0..WORD_W-1 is tried and the lowest matching position wins, which includes commas that straddle the word boundary.
- R6: With even_lane_i = 0, a comma found at position p sets the offset to p mod 10, and it leaves the block in lane (p - offset)/10.
- R7: With even_lane_i = 1, a comma found at position p sets the offset to p mod 20, so it always lands in an even lane.
- R8: The offset changes only on an accepted slide edge or on a comma found by an enabled pattern while slide_i is low. In every other cycle it is held.
- R9: word_o in the cycle after an input word equals window bits offset+WORD_W-1..offset, where offset is the value chosen in that same cycle. lane_comma_o and aligned_o are registered along with word_o.
- R10: aligned_o goes to 1 when the output word carries a flagged comma in a permitted lane: any lane in mode 0, an even lane in mode 1. An accepted slide edge clears it, and otherwise it holds its value.
- R11: Synchronous reset clears the offset, the stored previous word and all outputs. It also leaves the slide low count saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word_i | input | WORD_W | Raw deserialized word, bit 0 earliest |
| plus_pat_i | input | 10 | Plus comma pattern |
| minus_pat_i | input | 10 | Minus comma pattern |
| care_mask_i | input | 10 | 1 = pattern bit compared, 0 = don't care |
| plus_align_en_i | input | 1 | Plus comma may realign |
| minus_align_en_i | input | 1 | Minus comma may realign |
| detect_en_i | input | 1 | Enables the per-lane comma flags |
| even_lane_i | input | 1 | 0 = any lane, 1 = even lanes only |
| slide_i | input | 1 | Manual one-bit slip request |
| word_o | output | WORD_W | Realigned word |
| lane_comma_o | output | BYTES | Comma found in each output lane |
| aligned_o | output | 1 | A comma is sitting in a permitted lane |

## Verification
The assertions assume that slide_i and all configuration inputs are synchronous to clk and stable around its rising edge. They also assume WORD_W is 20 or 40, so an even-lane offset below 20 always fits inside the window. The bench changes every input only on the falling edge. It holds the configuration fixed across each directed comma injection and changes it in random mode only at block boundaries. It uses patterns whose shifted partial copies against zero fill cannot match, so each directed comma is the only one the block can see.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    localparam int SYM_W = 10;

    typedef logic [SYM_W-1:0] sym_t;

    // masked compare: a cleared care bit never causes a mismatch
    function automatic logic sym_match(sym_t s, sym_t pat, sym_t care);
        return ((s ^ pat) & care) == '0;
    endfunction

endpackage

// File: rtl/cwa_scan.sv
module cwa_scan
    import cwa_pkg::*;
#(
    parameter int WORD_W = 40,
    parameter int POS_W  = 6,
    localparam int CAT_W = WORD_W + SYM_W - 1
) (
    input  logic [CAT_W-1:0] cat_i,
    input  sym_t             plus_pat_i,
    input  sym_t             minus_pat_i,
    input  sym_t             care_i,
    input  logic             plus_en_i,
    input  logic             minus_en_i,
    output logic             hit_o,
    output logic [POS_W-1:0] pos_o
);

    logic [WORD_W-1:0] hit_vec;

    generate
        for (genvar p = 0; p < WORD_W; p++) begin : g_pos
            assign hit_vec[p] =
                (plus_en_i  && sym_match(cat_i[p +: SYM_W], plus_pat_i,  care_i)) ||
                (minus_en_i && sym_match(cat_i[p +: SYM_W], minus_pat_i, care_i));
        end
    endgenerate

    // lowest start position wins
    always_comb begin
        hit_o = 1'b0;
        pos_o = '0;
        for (int p = WORD_W - 1; p >= 0; p--) begin
            if (hit_vec[p]) begin
                hit_o = 1'b1;
                pos_o = POS_W'(p);
            end
        end
    end

endmodule

// File: rtl/cwa_barrel.sv
module cwa_barrel #(
    parameter int WORD_W = 40,
    parameter int POS_W  = 6,
    localparam int CAT_W = 2 * WORD_W - 1
) (
    input  logic [CAT_W-1:0]  cat_i,
    input  logic [POS_W-1:0]  sel_i,
    output logic [WORD_W-1:0] win_o
);

    always_comb begin
        win_o = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (sel_i == POS_W'(k)) begin
                win_o = cat_i[k +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/cwa_slip_gate.sv
module cwa_slip_gate #(
    parameter int SLIDE_GAP = 16,
    localparam int CNT_W    = $clog2(SLIDE_GAP + 2),
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SLIDE_GAP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic slide_i,
    output logic slip_o
);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] low_cnt;
    } gate_t;

    gate_t g_d, g_q;

    assign slip_o = slide_i && !g_q.prev && (g_q.low_cnt == CNT_SAT);

    always_comb begin
        g_d      = g_q;
        g_d.prev = slide_i;
        if (slide_i) begin
            g_d.low_cnt = '0;
        end else if (g_q.low_cnt != CNT_SAT) begin
            g_d.low_cnt = g_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q.prev    <= 1'b0;
            g_q.low_cnt <= CNT_SAT;
        end else begin
            g_q <= g_d;
        end
    end

    // independent spacing monitor: cycles since the last accepted slip
    logic [CNT_W:0] since_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= (CNT_W+1)'(SLIDE_GAP + 1);
        end else if (slip_o) begin
            since_q <= '0;
        end else if (since_q != (CNT_W+1)'(SLIDE_GAP + 1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r2_slide_spacing: assert property (@(posedge clk) disable iff (rst)
        slip_o |-> (since_q > (CNT_W+1)'(SLIDE_GAP)));

    a_r1_one_per_edge: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> !slip_o);

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
    import cwa_pkg::*;
#(
    parameter int BYTES     = 4,
    parameter int SLIDE_GAP = 16,
    localparam int WORD_W   = BYTES * SYM_W,
    localparam int POS_W    = $clog2(WORD_W),
    localparam int CAT_W    = 2 * WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic [SYM_W-1:0]  plus_pat_i,
    input  logic [SYM_W-1:0]  minus_pat_i,
    input  logic [SYM_W-1:0]  care_mask_i,
    input  logic              plus_align_en_i,
    input  logic              minus_align_en_i,
    input  logic              detect_en_i,
    input  logic              even_lane_i,
    input  logic              slide_i,
    output logic [WORD_W-1:0] word_o,
    output logic [BYTES-1:0]  lane_comma_o,
    output logic              aligned_o
);

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic [POS_W-1:0]  off;
        logic [WORD_W-1:0] word;
        logic [BYTES-1:0]  flags;
        logic              aligned;
    } st_t;

    st_t st_d, st_q;

    logic [CAT_W-1:0]  cat;
    logic              hit;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  tgt;
    logic [POS_W-1:0]  off_nx;
    logic              slip;
    logic              auto_move;
    logic [WORD_W-1:0] win;
    logic [BYTES-1:0]  lane_hit;
    logic [BYTES-1:0]  lane_ok;

    // previous word in the low half: lower index = earlier bit
    assign cat = {rx_word_i[WORD_W-2:0], st_q.prev};

    cwa_scan #(.WORD_W(WORD_W), .POS_W(POS_W)) u_scan (
        .cat_i       (cat[WORD_W+SYM_W-2:0]),
        .plus_pat_i  (plus_pat_i),
        .minus_pat_i (minus_pat_i),
        .care_i      (care_mask_i),
        .plus_en_i   (plus_align_en_i),
        .minus_en_i  (minus_align_en_i),
        .hit_o       (hit),
        .pos_o       (pos)
    );

    cwa_slip_gate #(.SLIDE_GAP(SLIDE_GAP)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .slide_i (slide_i),
        .slip_o  (slip)
    );

    // boundary target: one symbol grid, or a two-symbol grid for even lanes
    assign tgt = even_lane_i ? (pos % POS_W'(2 * SYM_W)) : (pos % POS_W'(SYM_W));
    assign auto_move = hit && !slide_i && (tgt != st_q.off);

    always_comb begin
        off_nx = st_q.off;
        if (slip) begin
            off_nx = (st_q.off == POS_W'(WORD_W - 1)) ? '0 : st_q.off + 1'b1;
        end else if (auto_move) begin
            off_nx = tgt;
        end
    end

    cwa_barrel #(.WORD_W(WORD_W), .POS_W(POS_W)) u_barrel (
        .cat_i (cat),
        .sel_i (off_nx),
        .win_o (win)
    );

    generate
        for (genvar l = 0; l < BYTES; l++) begin : g_lane
            assign lane_hit[l] = detect_en_i &&
                (sym_match(win[l*SYM_W +: SYM_W], plus_pat_i,  care_mask_i) ||
                 sym_match(win[l*SYM_W +: SYM_W], minus_pat_i, care_mask_i));
            if (l % 2 == 0) begin : g_even
                assign lane_ok[l] = lane_hit[l];
            end else begin : g_odd
                assign lane_ok[l] = lane_hit[l] && !even_lane_i;
            end
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.prev  = rx_word_i;
        st_d.off   = off_nx;
        st_d.word  = win;
        st_d.flags = lane_hit;
        if (slip) begin
            st_d.aligned = 1'b0;
        end else if (|lane_ok) begin
            st_d.aligned = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o       = st_q.word;
    assign lane_comma_o = st_q.flags;
    assign aligned_o    = st_q.aligned;

    a_r1_slip_step: assert property (@(posedge clk) disable iff (rst)
        slip |=> (st_q.off == (($past(st_q.off) == POS_W'(WORD_W - 1)) ?
                               POS_W'(0) : $past(st_q.off) + 1'b1)));

    a_r3_slide_blocks_auto: assert property (@(posedge clk) disable iff (rst)
        (slide_i && !slip) |=> $stable(st_q.off));

    a_r8_hold_offset: assert property (@(posedge clk) disable iff (rst)
        (!slide_i && !hit) |=> $stable(st_q.off));

    a_r7_even_grid: assert property (@(posedge clk) disable iff (rst)
        (auto_move && even_lane_i) |=> (st_q.off < POS_W'(2 * SYM_W)));

endmodule

// File: tb/sim_comma_word_aligner.sv
module sim_comma_word_aligner;

    localparam int BYTES = 4;
    localparam int W     = BYTES * 10;
    localparam int GAP   = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic [W-1:0]     raw;
    logic [9:0]       plus_pat, minus_pat, care;
    logic             pen, men, den, even, slide;
    logic [W-1:0]     word_o;
    logic [BYTES-1:0] flags;
    logic             al;

    comma_word_aligner #(.BYTES(BYTES), .SLIDE_GAP(GAP)) u0 (
        .clk (clk), .rst (rst), .rx_word_i (raw),
        .plus_pat_i (plus_pat), .minus_pat_i (minus_pat), .care_mask_i (care),
        .plus_align_en_i (pen), .minus_align_en_i (men), .detect_en_i (den),
        .even_lane_i (even), .slide_i (slide),
        .word_o (word_o), .lane_comma_o (flags), .aligned_o (al)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected-state model built from the requirements
    logic [W-1:0]     m_prev, m_word;
    logic [BYTES-1:0] m_flags;
    logic             m_al, m_ps;
    int               m_off, m_low;

    function automatic bit pm(logic [9:0] s, logic [9:0] p, logic [9:0] m);
        return ((s ^ p) & m) == 10'd0;
    endfunction

    function automatic logic [W-1:0] win2(logic [W-1:0] x, int o);
        logic [2*W-1:0] c;
        c = {x, x};
        return c[o +: W];
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = '0; m_word = '0; m_flags = '0; m_al = 1'b0;
        m_ps = 1'b0; m_off = 0; m_low = GAP + 1;
    endtask

    task automatic model_step();
        logic [2*W-1:0]   c;
        logic [W-1:0]     w;
        logic [BYTES-1:0] fl;
        int pos, noff, tgt;
        bit sl, ok;
        c = {raw, m_prev};
        pos = -1;
        for (int p = 0; p < W; p++) begin
            if (pos < 0 && ((pen && pm(c[p +: 10], plus_pat, care)) ||
                            (men && pm(c[p +: 10], minus_pat, care))))
                pos = p;
        end
        sl = slide && !m_ps && (m_low > GAP);
        noff = m_off;
        if (sl) noff = (m_off + 1) % W;
        else if (pos >= 0 && !slide) begin
            tgt = even ? pos % 20 : pos % 10;
            noff = tgt;
        end
        w = c[noff +: W];
        ok = 1'b0;
        for (int l = 0; l < BYTES; l++) begin
            fl[l] = den && (pm(w[l*10 +: 10], plus_pat, care) || pm(w[l*10 +: 10], minus_pat, care));
            if (fl[l] && (!even || (l % 2 == 0))) ok = 1'b1;
        end
        if (sl) m_al = 1'b0;
        else if (ok) m_al = 1'b1;
        m_prev = raw; m_off = noff; m_word = w; m_flags = fl;
        m_low = slide ? 0 : ((m_low > GAP) ? GAP + 1 : m_low + 1);
        m_ps = slide;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R9 word", 64'(word_o), 64'(m_word));
        chk("R4 flags", 64'(flags), 64'(m_flags));
        chk("R10 aligned", 64'(al), 64'(m_al));
    endtask

    task automatic do_reset();
        rst = 1'b1; raw = '0; slide = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic inject(int p, logic [9:0] pat);
        logic [2*W-1:0] s;
        s = {{(2*W-10){1'b0}}, pat} << p;
        raw = s[W-1:0];   step();
        raw = s[2*W-1:W]; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] s;
        logic [W-1:0]   x;
        logic [9:0]     pt;
        int eo, ln;
        void'($urandom(32'd4711));
        plus_pat = 10'h17C; minus_pat = 10'h283; care = '1;
        pen = 1'b1; men = 1'b1; den = 1'b1; even = 1'b0;
        rst = 1'b1; raw = '0; slide = 1'b0;
        @(posedge clk);
        do_reset();
        chk("R11 reset word", 64'(word_o), 64'd0);
        chk("R11 reset flags", 64'(flags), 64'd0);
        chk("R11 reset aligned", 64'(al), 64'd0);

        // every bit offset, both lane modes
        for (int md = 0; md < 2; md++) begin
            for (int p = 0; p < W; p++) begin
                do_reset();
                even = md[0]; pen = 1'b1; men = 1'b1; den = 1'b1; care = '1;
                pt = p[0] ? minus_pat : plus_pat;
                inject(p, pt);
                eo = p % (md == 1 ? 20 : 10);
                ln = (p - eo) / 10;
                if (md == 1) chk("R7 even lane", 64'(flags), 64'(BYTES'(1) << ln));
                else         chk("R6 any lane", 64'(flags), 64'(BYTES'(1) << ln));
                chk("R5 comma in lane", 64'(word_o[ln*10 +: 10]), 64'(pt));
                chk("R10 aligned set", 64'(al), 64'd1);
                raw = '0;
            end
        end
        even = 1'b0;

        // manual slide spacing
        do_reset();
        pen = 1'b0; men = 1'b0; den = 1'b1;
        x = {$urandom, $urandom}; raw = x; step();
        slide = 1'b1; step(); slide = 1'b0;
        chk("R1 one bit per edge", 64'(word_o), 64'(win2(x, 1)));
        repeat (GAP) step();
        slide = 1'b1; step(); slide = 1'b0;
        chk("R2 early edge ignored", 64'(word_o), 64'(win2(x, 1)));
        repeat (GAP + 1) step();
        slide = 1'b1; repeat (4) step(); slide = 1'b0;
        chk("R2 spaced edge taken, R1 held high gives one move", 64'(word_o), 64'(win2(x, 2)));
        step();

        // slide high freezes automatic alignment
        do_reset();
        pen = 1'b1; men = 1'b1; den = 1'b1; raw = '0; step();
        s = {{(2*W-10){1'b0}}, plus_pat} << 5;
        slide = 1'b1; raw = s[W-1:0]; step(); raw = s[2*W-1:W]; step();
        chk("R3 slide blocks realign", 64'(word_o), 64'(s[1 +: W]));
        slide = 1'b0; raw = '0; step();

        // offset held without enabled match
        do_reset();
        pen = 1'b0; men = 1'b0; den = 1'b1;
        s = {{(2*W-10){1'b0}}, plus_pat} << 13;
        inject(13, plus_pat);
        chk("R8 disabled match holds offset", 64'(word_o), 64'(s[W-1:0]));
        chk("R8 no lane flag", 64'(flags), 64'd0);
        raw = '0; step();
        pen = 1'b1;
        inject(20, plus_pat);
        chk("R8 same offset kept", 64'(flags), 64'(4'b0100));

        // care mask
        do_reset();
        pen = 1'b1; men = 1'b0; care = 10'b1101110111;
        inject(10, plus_pat ^ 10'b0010001000);
        chk("R4 masked bits ignored", 64'(flags), 64'(4'b0010));
        do_reset();
        inject(10, plus_pat ^ 10'b0000000100);
        chk("R4 cared bit mismatch", 64'(flags), 64'd0);
        care = '1;

        // per-pattern align enables
        do_reset();
        pen = 1'b0; men = 1'b1;
        inject(7, plus_pat);
        chk("R4 plus disabled no move", 64'(flags), 64'd0);
        raw = '0; step();
        inject(7, minus_pat);
        chk("R4 minus realigns", 64'(flags), 64'(4'b0001));

        // detect disabled still aligns
        do_reset();
        pen = 1'b1; men = 1'b1; den = 1'b0;
        inject(3, plus_pat);
        chk("R4 detect off clears flags", 64'(flags), 64'd0);
        chk("R6 aligned data", 64'(word_o[9:0]), 64'(plus_pat));
        den = 1'b1;

        // constrained random traffic
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if (i % 256 == 0) begin
                pen = 1'($urandom % 2); men = 1'($urandom % 2);
                den = 1'($urandom % 4 != 0); even = 1'($urandom % 2);
            end
            x = {$urandom, $urandom};
            if ($urandom % 6 == 0) begin
                int q;
                q = int'($urandom % (W - 9));
                x[q +: 10] = ($urandom % 2 == 1) ? plus_pat : minus_pat;
            end
            raw = x;
            slide = ($urandom % 24 == 0);
            step();
        end
        slide = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule